// File: doc/BRIEF.md
# Round-Robin Channel Multiplexer with Frame Separator

This block merges a set of parallel converter channels into a single word stream. Every channel can present one word at any time. The block keeps that word in a one-entry holding register until the channel's turn in the output frame comes round. A frame starts with a fixed separator word and then gives one slot to each channel in ascending channel order. A slot carries the word being held for that channel, or an all-zero filler word if nothing is pending. The slot a word sits in therefore tells the receiver which channel it came from.

Output words are paced by a programmable divider, so the frame length in time can be matched to the serial frame time of the channels. A full frame of 19 words corresponds to one 900 ns channel frame. A channel that delivers a second word before its slot has drained the first loses the newer word. This raises a sticky per-channel overrun flag.

Top module: `rrmux_top`

## Requirements
- R1: While `rst_n` is low and on the first clock after its release, `out_valid`, `out_sof`, `out_data` and every `overrun` bit are 0, and all holding registers are empty.
- R2: Each frame is NCH+1 output words long. Its first word is the separator 32'hDEA5C3A1, and `out_sof` is high with that word and with no other.
- R3: The word in slot k (k = 1..NCH, counted from the separator at slot 0) belongs only to channel k-1. When that channel's register holds a word, the slot carries {1'b0, held word}, and emitting the slot empties the register.
- R4: A slot whose channel register is empty when the slot is emitted carries 32'h00000000.
- R5: `out_valid` is high for exactly one clock with every emitted word, separator and filler included. When `out_valid` is low, `out_data` keeps its last value.
- R6: A write to a channel whose register is full, on a clock where that channel's slot is not being emitted, is dropped. The held word stays unchanged and the channel's `overrun` bit goes high. That bit stays high until reset.
- R7: Words are emitted once every WORD_DIV clocks (default 2). The first word appears WORD_DIV clocks after reset is released.
- R8: A write that arrives on the same clock its channel's slot is emitted is accepted. It refills the register for the next frame and raises no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NCH | Per-channel write strobe |
| in_data | input | NCH*DATA_W | Channel words, channel c in bits [c*DATA_W +: DATA_W] |
| out_valid | output | 1 | High for one clock with each emitted word |
| out_sof | output | 1 | Marks the separator word that opens a frame |
| out_data | output | DATA_W+1 | Emitted word: separator, channel word or zero filler |
| overrun | output | NCH | Sticky per-channel overrun flags |

## Verification
A slot counter that is off by one shows up within one frame. Channel words move into the neighbouring slot, and the separator lands at a frame position other than every nineteenth word. A holding register whose full bit does not clear on drain repeats the same word in the next frame where a zero filler was expected. One that never fills emits zeros where data should be. Both appear at the channel's next slot, at most one frame later. Wrong overrun handling shows on the flags one clock after the conflicting write, or as a lost refill in the following frame.

// File: rtl/rrmux_pkg.sv
package rrmux_pkg;
    localparam int unsigned DEF_NCH      = 18;
    localparam int unsigned DEF_DATA_W   = 31;
    localparam int unsigned DEF_WORD_DIV = 2;
    // low bits of the separator; bit above them is always set
    localparam logic [30:0] DEF_SEP_LOW  = 31'h5EA5_C3A1;
endpackage

// File: rtl/rrmux_pace.sv
module rrmux_pace #(
    parameter int unsigned WORD_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DW = (WORD_DIV > 1) ? $clog2(WORD_DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
    } pace_t;

    pace_t st_d, st_q;

    assign tick = (st_q.cnt == DW'(WORD_DIV - 1));

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rrmux_slot.sv
module rrmux_slot #(
    parameter int unsigned NCH = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    output logic           sep,
    output logic [NCH-1:0] drain
);
    localparam int unsigned SW = $clog2(NCH + 1);

    typedef struct packed {
        logic [SW-1:0] slot;
    } slot_t;

    slot_t st_d, st_q;

    assign sep = tick && (st_q.slot == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_drain
        assign drain[c] = tick && (st_q.slot == SW'(c + 1));
    end

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.slot == SW'(NCH)) st_d.slot = '0;
            else                       st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rrmux_hold.sv
module rrmux_hold #(
    parameter int unsigned DATA_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              drain,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              ovr
);
    typedef struct packed {
        logic              full;
        logic              ovr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    assign full = st_q.full;
    assign data = st_q.data;
    assign ovr  = st_q.ovr;

    always_comb begin
        st_d = st_q;
        if (drain) st_d.full = 1'b0;
        if (wr) begin
            if (st_q.full && !drain) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.full = 1'b1;
                st_d.data = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rrmux_top.sv
module rrmux_top
    import rrmux_pkg::*;
#(
    parameter int unsigned       NCH      = DEF_NCH,
    parameter int unsigned       DATA_W   = DEF_DATA_W,
    parameter int unsigned       WORD_DIV = DEF_WORD_DIV,
    parameter logic [DATA_W-1:0] SEP_LOW  = DATA_W'(DEF_SEP_LOW)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        in_valid,
    input  logic [NCH*DATA_W-1:0] in_data,
    output logic                  out_valid,
    output logic                  out_sof,
    output logic [DATA_W:0]       out_data,
    output logic [NCH-1:0]        overrun
);
    localparam int unsigned OW = DATA_W + 1;

    typedef struct packed {
        logic          valid;
        logic          sof;
        logic [OW-1:0] data;
    } out_t;

    logic              tick;
    logic              sep;
    logic [NCH-1:0]    drain;
    logic [NCH-1:0]    full;
    logic [DATA_W-1:0] hdata [NCH];
    logic [DATA_W-1:0] pick;

    out_t st_d, st_q;

    rrmux_pace #(.WORD_DIV(WORD_DIV)) u_pace (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    rrmux_slot #(.NCH(NCH)) u_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .sep  (sep),
        .drain(drain)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rrmux_hold #(.DATA_W(DATA_W)) u_hold (
            .clk  (clk),
            .rst_n(rst_n),
            .wr   (in_valid[c]),
            .wdata(in_data[c*DATA_W +: DATA_W]),
            .drain(drain[c]),
            .full (full[c]),
            .data (hdata[c]),
            .ovr  (overrun[c])
        );
    end

    always_comb begin
        pick = '0;
        for (int c = 0; c < NCH; c++) begin
            if (drain[c] && full[c]) pick = hdata[c];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = tick;
        st_d.sof   = sep;
        if (tick) begin
            if (sep) st_d.data = {1'b1, SEP_LOW};
            else     st_d.data = {1'b0, pick};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_sof   = st_q.sof;
    assign out_data  = st_q.data;
endmodule

// File: rtl/rrmux_chk.sv
module rrmux_chk #(
    parameter int unsigned       NCH      = 18,
    parameter int unsigned       DATA_W   = 31,
    parameter int unsigned       WORD_DIV = 2,
    parameter logic [DATA_W-1:0] SEP_LOW  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_sof,
    input logic [DATA_W:0]   out_data,
    input logic [NCH-1:0]    overrun
);
    localparam int unsigned CW = $clog2(NCH + 2) + 1;

    logic [CW-1:0] words_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            seen_q  <= 1'b0;
        end else if (out_valid) begin
            if (out_sof) begin
                words_q <= CW'(1);
                seen_q  <= 1'b1;
            end else begin
                words_q <= words_q + 1'b1;
            end
        end
    end

    assert_sof_is_sep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_data == {1'b1, SEP_LOW}));

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof && seen_q) |-> (words_q == CW'(NCH + 1)));

    assert_sof_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seen_q) |-> out_sof);

    assert_data_msb_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> !out_data[DATA_W]);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> (out_valid || $stable(out_data)));

    assert_sticky_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun & $past(overrun)) == $past(overrun));

    if (WORD_DIV > 1) begin : g_gap
        assert_valid_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |=> !out_valid);
    end
endmodule

bind rrmux_top rrmux_chk #(
    .NCH     (NCH),
    .DATA_W  (DATA_W),
    .WORD_DIV(WORD_DIV),
    .SEP_LOW (SEP_LOW)
) u_rrmux_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_sof  (out_sof),
    .out_data (out_data),
    .overrun  (overrun)
);

// File: tb/rrmux_top_bench.sv
module rrmux_top_bench;
    localparam int NCH = 18;
    localparam int DW  = 31;
    localparam int DIV = 2;
    localparam logic [31:0] SEPW = 32'hDEA5C3A1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  in_valid = '0;
    logic [NCH*DW-1:0] in_data = '0;
    logic            out_valid;
    logic            out_sof;
    logic [31:0]     out_data;
    logic [NCH-1:0]  overrun;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    rrmux_top u_rrmux_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
        .overrun(overrun)
    );

    // behavioural reference: pending words per channel, frame position counters
    logic [DW-1:0]  pend [NCH][$];
    logic [NCH-1:0] m_ovr;
    int             m_phase, m_pos;
    logic           m_valid, m_sof;
    logic [31:0]    m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) pend[c].delete();
            m_ovr = '0; m_phase = 0; m_pos = 0;
            m_valid = 0; m_sof = 0; m_data = '0;
        end else begin
            int emit_ch;
            emit_ch = -1;
            m_valid = (m_phase == DIV - 1);
            m_sof   = m_valid && (m_pos == 0);
            if (m_valid) begin
                if (m_pos == 0) m_data = SEPW;
                else begin
                    emit_ch = m_pos - 1;
                    if (pend[emit_ch].size() != 0) m_data = {1'b0, pend[emit_ch].pop_front()};
                    else m_data = 32'h0;
                end
                m_pos = (m_pos + 1) % (NCH + 1);
            end
            for (int c = 0; c < NCH; c++) begin
                if (in_valid[c]) begin
                    if (pend[c].size() != 0) m_ovr[c] = 1'b1;
                    else pend[c].push_back(in_data[c*DW +: DW]);
                end
            end
            m_phase = (m_phase + 1) % DIV;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check({31'b0, out_valid}, 32'h0, "R1 valid in reset");
        check({31'b0, out_sof},   32'h0, "R1 sof in reset");
        check(out_data,           32'h0, "R1 data in reset");
        check({14'b0, overrun},   32'h0, "R1 overrun in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check({31'b0, out_valid}, 32'h0, "R1 R7 no word first clock");
        for (int t = 0; t < 1500; t++) begin
            @(negedge clk);
            cyc = t;
            check({31'b0, out_valid}, {31'b0, m_valid}, "R5 R7 valid");
            check({31'b0, out_sof},   {31'b0, m_sof},   "R2 sof");
            if (m_sof)                check(out_data, m_data, "R2 separator");
            else if (m_data == 32'h0) check(out_data, m_data, "R4 filler");
            else                      check(out_data, m_data, "R3 R5 data");
            check({14'b0, overrun}, {14'b0, m_ovr}, "R6 R8 overrun");
            // stimulus
            in_valid = '0;
            for (int c = 0; c < NCH; c++) begin
                in_data[c*DW +: DW] = {c[4:0], 26'($urandom)};
                if (t >= 100 && t < 700)
                    in_valid[c] = ((t % 38) == 2 * c);       // one write per frame, no overrun
                else if (t >= 700 && t < 1000)
                    in_valid[c] = ((t % 38) == 2 * c + 1);   // lands on the drain clock (R8)
                else if (t >= 1000)
                    in_valid[c] = (($urandom % 6) == 0);     // dense: overruns (R6)
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule